// File: doc/BRIEF.md
# Batched FIFO Drain Port with Fill-Level Snapshot

This block sits on a 32-bit address, 32-bit data register bus as a read-only slave. It collects 12-bit converter samples, packs each pair into one 24-bit word and queues the words in a local FIFO. A host empties the FIFO with one batched transaction of fixed length. The batch starts with a single read of the status address and continues with any number of reads of the pop address, all at the same address with no increment.

The status read returns the current fill level. In the same access it loads that level into a hidden countdown. Each later pop read that finds the countdown nonzero returns the next queued word and decrements the countdown. A pop read that finds the countdown at zero returns a fixed filler constant and leaves the FIFO alone. An over-long burst therefore cannot underflow the queue. The first word of the batch tells the host how many of the following words are real.

Words that arrive while the FIFO is full are dropped, and a sticky flag records the loss for the next status read.

Top module: `sample_drain_port`

## Requirements
- R1: A synchronous reset clears the FIFO, the countdown, the overflow flag and any half-built sample pair. After reset, `rd_data` reads zero and a status read returns zero.
- R2: Of two consecutive samples, the earlier one lands in bits [11:0] and the later one in bits [23:12] of a FIFO word. Bits [31:24] of a real word read zero. No word is queued until both samples of a pair are present.
- R3: A read of address 0x80000000 (status) returns the fill level in the low bits and the overflow flag in bit 31, with every other bit zero. All read data appears on `rd_data` one clock after the read strobe.
- R4: A status read copies the fill level it returns into the countdown.
- R5: A read of address 0x80000001 (pop) while the countdown is nonzero returns the oldest queued word and decrements the countdown. Words come out in arrival order.
- R6: A pop read while the countdown is zero returns 0x00DEAD00, leaves the countdown at zero and removes nothing from the FIFO.
- R7: A packed word that meets a full FIFO is discarded and sets the overflow flag. The flag stays set until a status read clears it.
- R8: A read of any other address returns zero and changes neither the countdown, the FIFO nor the overflow flag.
- R9: A word queued in the same cycle as a pop leaves the fill level unchanged.
- R10: Words queued after a status read are not returned by pops of that batch. They appear only after the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_data | input | 12 | Converter sample |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 32 | Bus read address |
| rd_data | output | 32 | Registered read data, valid the clock after `rd_en` |

## Verification
The drain path is exercised with batches that are shorter than the queue, exactly as long as the queue, and longer than the queue. These separate correct gating by the countdown from gating by FIFO emptiness. Words arrive after a snapshot to show that the countdown, not the live fill level, bounds a batch. A filled queue followed by one extra pair shows both the drop and the clear-on-read of the flag.

Unmapped addresses are read between pops to show that they have no side effects. A pair completes in the very cycle of a pop to show the simultaneous push and pop. A reset in the middle of a pair shows that the orphan half is discarded.

// File: rtl/drain_pkg.sv
package drain_pkg;
  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_STAT = 2'd1,
    SEL_POP  = 2'd2,
    SEL_FILL = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pair_packer.sv
module pair_packer #(
  parameter int SMP_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid_i,
  input  logic [SMP_W-1:0]   smp_data_i,
  output logic               word_valid_o,
  output logic [2*SMP_W-1:0] word_o
);
  logic [SMP_W-1:0] low_q;
  logic             have_low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q        <= '0;
      have_low_q   <= 1'b0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (smp_valid_i) begin
        if (have_low_q) begin
          word_o       <= {smp_data_i, low_q};
          word_valid_o <= 1'b1;
          have_low_q   <= 1'b0;
        end else begin
          low_q      <= smp_data_i;
          have_low_q <= 1'b1;
        end
      end
    end
  end

  // R2: a word needs two samples, so two words never come back to back
  assert_pair_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int WORD_W     = 24,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                pop_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [DEPTH_LOG2:0] count_o,
  output logic                full_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [WORD_W-1:0]     mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr_q, rd_ptr_q;

  assign full_o = (count_o == (DEPTH_LOG2+1)'(DEPTH));

  // storage and registered read port, shaped for block RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr_q] <= wdata_i;
    if (pop_i)  rdata_o <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (count_o != '0));
  assert_fill_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> (count_o == $past(count_o)));
endmodule

// File: rtl/drain_decode.sv
module drain_decode
  import drain_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              DATA_W      = 32,
  parameter int              WORD_W      = 24,
  parameter int              CNT_W       = 5,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] POP_ADDR  = 32'h8000_0001,
  parameter logic [DATA_W-1:0] FILLER    = 32'h00DE_AD00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  fill_i,
  input  logic              ovf_set_i,
  input  logic [WORD_W-1:0] fifo_rdata_i,
  output logic              pop_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PAD_W = DATA_W - 1 - CNT_W;

  rd_sel_e           sel_q;
  logic [CNT_W-1:0]  left_q;
  logic              ovf_q;
  logic [DATA_W-1:0] stat_q;
  logic              hit_stat, hit_pop, stat_rd;

  assign hit_stat = (rd_addr_i == STAT_ADDR);
  assign hit_pop  = (rd_addr_i == POP_ADDR);
  assign stat_rd  = rd_en_i && hit_stat;
  assign pop_o    = rd_en_i && hit_pop && (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_ZERO;
      left_q <= '0;
      ovf_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      sel_q <= SEL_ZERO;
      if (stat_rd) begin
        sel_q  <= SEL_STAT;
        stat_q <= {ovf_q, {PAD_W{1'b0}}, fill_i};
        left_q <= fill_i;
      end else if (rd_en_i && hit_pop) begin
        if (left_q != '0) begin
          sel_q  <= SEL_POP;
          left_q <= left_q - 1'b1;
        end else begin
          sel_q  <= SEL_FILL;
        end
      end
      // a fresh drop wins over the clear of the same cycle
      if (ovf_set_i)    ovf_q <= 1'b1;
      else if (stat_rd) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_STAT: rd_data_o = stat_q;
      SEL_POP:  rd_data_o = {{(DATA_W-WORD_W){1'b0}}, fifo_rdata_i};
      SEL_FILL: rd_data_o = FILLER;
      default:  rd_data_o = '0;
    endcase
  end

  assert_left_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    left_q <= fill_i);
  assert_snapshot_R4: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (left_q == $past(fill_i)));
  assert_filler_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && hit_pop && left_q == '0) |=> (rd_data_o == FILLER && left_q == '0));
  assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !hit_stat && !hit_pop) |=> (rd_data_o == '0 && $stable(left_q)));
endmodule

// File: rtl/sample_drain_port.sv
module sample_drain_port #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                SMP_W      = 12,
  parameter int                DEPTH_LOG2 = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] POP_ADDR   = 32'h8000_0001,
  parameter logic [DATA_W-1:0] FILLER     = 32'h00DE_AD00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORD_W = 2 * SMP_W;
  localparam int CNT_W  = DEPTH_LOG2 + 1;

  logic              pk_valid;
  logic [WORD_W-1:0] pk_word;
  logic              fifo_full, fifo_push, fifo_pop, drop;
  logic [CNT_W-1:0]  fill;
  logic [WORD_W-1:0] fifo_rdata;

  assign fifo_push = pk_valid && !fifo_full;
  assign drop      = pk_valid && fifo_full;

  pair_packer #(.SMP_W(SMP_W)) i_packer (
    .clk, .rst,
    .smp_valid_i (smp_valid),
    .smp_data_i  (smp_data),
    .word_valid_o(pk_valid),
    .word_o      (pk_word)
  );

  word_fifo #(.WORD_W(WORD_W), .DEPTH_LOG2(DEPTH_LOG2)) i_fifo (
    .clk, .rst,
    .push_i (fifo_push),
    .wdata_i(pk_word),
    .pop_i  (fifo_pop),
    .rdata_o(fifo_rdata),
    .count_o(fill),
    .full_o (fifo_full)
  );

  drain_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
    .STAT_ADDR(STAT_ADDR), .POP_ADDR(POP_ADDR), .FILLER(FILLER)
  ) i_decode (
    .clk, .rst,
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .fill_i      (fill),
    .ovf_set_i   (drop),
    .fifo_rdata_i(fifo_rdata),
    .pop_o       (fifo_pop),
    .rd_data_o   (rd_data)
  );
endmodule

// File: tb/test_sample_drain_port.sv
module test_sample_drain_port;
  localparam logic [31:0] STAT = 32'h8000_0000;
  localparam logic [31:0] POP  = 32'h8000_0001;
  localparam logic [31:0] FILL = 32'h00DE_AD00;

  localparam logic [1:0] OP_SMP = 2'd0, OP_STAT = 2'd1, OP_POP = 2'd2, OP_ADR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] arg;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{OP_STAT, 32'h0, 32'h0, 4'd1},          // R1 empty after reset
    '{OP_POP,  32'h0, FILL,  4'd6},          // R6 zero countdown
    '{OP_SMP,  32'h123, 32'h0, 4'd0},
    '{OP_STAT, 32'h0, 32'h0, 4'd2},          // R2 half pair not queued
    '{OP_SMP,  32'hABC, 32'h0, 4'd0},
    '{OP_SMP,  32'h001, 32'h0, 4'd0},
    '{OP_SMP,  32'hFFF, 32'h0, 4'd0},
    '{OP_STAT, 32'h0, 32'h2, 4'd3},          // R3 fill 2, R4 snapshot
    '{OP_SMP,  32'h456, 32'h0, 4'd0},
    '{OP_SMP,  32'h789, 32'h0, 4'd0},
    '{OP_ADR,  32'h8000_0002, 32'h0, 4'd8},  // R8 unmapped
    '{OP_ADR,  32'h0000_0000, 32'h0, 4'd8},  // R8 unmapped
    '{OP_POP,  32'h0, 32'h00AB_C123, 4'd5},  // R5 oldest first, R2 layout
    '{OP_POP,  32'h0, 32'h00FF_F001, 4'd5},
    '{OP_POP,  32'h0, FILL,  4'd10},         // R10 later word gated
    '{OP_POP,  32'h0, FILL,  4'd6},
    '{OP_STAT, 32'h0, 32'h1, 4'd6},          // R6 filler popped nothing
    '{OP_POP,  32'h0, 32'h0078_9456, 4'd5},
    '{OP_POP,  32'h0, FILL,  4'd6},
    '{OP_STAT, 32'h0, 32'h0, 4'd5},
    '{OP_SMP,  32'h001, 32'h0, 4'd0}, '{OP_SMP, 32'h002, 32'h0, 4'd0},
    '{OP_SMP,  32'h003, 32'h0, 4'd0}, '{OP_SMP, 32'h004, 32'h0, 4'd0},
    '{OP_SMP,  32'h005, 32'h0, 4'd0}, '{OP_SMP, 32'h006, 32'h0, 4'd0},
    '{OP_SMP,  32'h007, 32'h0, 4'd0}, '{OP_SMP, 32'h008, 32'h0, 4'd0},
    '{OP_SMP,  32'h009, 32'h0, 4'd0}, '{OP_SMP, 32'h00A, 32'h0, 4'd0},
    '{OP_STAT, 32'h0, 32'h8000_0004, 4'd7},  // R7 full, fifth word dropped
    '{OP_STAT, 32'h0, 32'h4, 4'd7},          // R7 flag cleared by read
    '{OP_POP,  32'h0, 32'h0000_2001, 4'd5},
    '{OP_POP,  32'h0, 32'h0000_4003, 4'd5},
    '{OP_POP,  32'h0, 32'h0000_6005, 4'd5},
    '{OP_POP,  32'h0, 32'h0000_8007, 4'd7},  // R7 last kept word, not the dropped one
    '{OP_POP,  32'h0, FILL,  4'd6}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sample_drain_port #(.DEPTH_LOG2(2)) i_sample_drain_port (
    .clk, .rst, .smp_valid, .smp_data, .rd_en, .rd_addr, .rd_data
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_sample(input logic [11:0] d);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en   = 1'b0;
    rd_addr = '0;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, rd_data, 32'h0);  // R1 idle output after reset

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_SMP:  do_sample(VEC[i].arg[11:0]);
        OP_STAT: begin do_read(STAT, d); check(int'(VEC[i].req), d, VEC[i].exp); end
        OP_POP:  begin do_read(POP, d);  check(int'(VEC[i].req), d, VEC[i].exp); end
        default: begin do_read(VEC[i].arg, d); check(int'(VEC[i].req), d, VEC[i].exp); end
      endcase
    end

    // R1: reset in the middle of a pair drops the orphan half
    do_sample(12'h555);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1, rd_data, 32'h0);
    do_sample(12'h111);
    do_sample(12'h222);
    do_read(STAT, d); check(1, d, 32'h1);
    do_read(POP, d);  check(1, d, 32'h0022_2111);

    // R9: a word is queued in the cycle of a pop
    do_sample(12'h0AA);
    do_sample(12'h0BB);
    do_read(STAT, d); check(9, d, 32'h1);
    @(negedge clk); smp_valid = 1'b1; smp_data = 12'h0CC;
    @(negedge clk); smp_data = 12'h0DD;
    @(negedge clk); smp_valid = 1'b0; rd_en = 1'b1; rd_addr = POP;
    @(negedge clk); rd_en = 1'b0; rd_addr = '0;
    check(9, rd_data, 32'h000B_B0AA);
    do_read(STAT, d); check(9, d, 32'h1);
    do_read(POP, d);  check(9, d, 32'h000D_D0CC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule